// File: doc/BRIEF.md
# Addressable Bit Latch Bank with Conditional Clear

This block keeps a small bank of output bits, eight by default. Each bit can be written on its own through a binary index and a single data line. Two active-low controls set the mode. The write strobe `wr_n` lets the data reach the indexed bit. The zeroing control `zap_n` clears bits, but what it clears depends on the strobe.

With the strobe idle, `zap_n` low clears the whole bank. With the strobe active, `zap_n` low clears every bit except the indexed one, and the indexed bit still takes the data. In that mode the bank works as a one-of-N demultiplexer.

All inputs are sampled on the rising edge of `clk`, and the outputs come straight from registers. A synchronous active-high `rst` zeroes the bank independently of `zap_n`. A typical use is a bank of individually set control flags, where the part holding a flag changes its bit without read-modify-write logic.

Top module: `sel_latch_bank`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every bit of `q` is 0 after that edge, whatever the other inputs are.
- R2: The index `idx` is an unsigned binary number with bit 2 as the most significant bit. Value k (0 to 7) selects `q[k]`, so `idx`=0 selects `q[0]` and `idx`=7 selects `q[7]`.
- R3: Latch mode is `zap_n`=1 with `wr_n`=0. At each edge in this mode the selected bit takes `din`, and every other bit keeps its value.
- R4: Hold mode is `zap_n`=1 with `wr_n`=1. In this mode no bit changes, whatever `din` and `idx` do.
- R5: When `wr_n` returns high, the selected bit keeps the `din` value it took at the last edge with `wr_n` low, for as long as hold mode lasts.
- R6: Demux mode is `zap_n`=0 with `wr_n`=0. After an edge in this mode the selected bit equals `din` and every other bit is 0.
- R7: Clear mode is `zap_n`=0 with `wr_n`=1. After an edge in this mode all bits are 0.
- R8: `q` changes only at rising edges of `clk`. A change on any input shows on `q` after the next rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, zeroes all bits |
| idx | input | IDX_W (3) | Binary index of the bit to write |
| din | input | 1 | Data value for the selected bit |
| wr_n | input | 1 | Active-low write strobe |
| zap_n | input | 1 | Active-low conditional zeroing control |
| q | output | 2**IDX_W (8) | Registered bank outputs |

## Verification
Every result is due exactly one rising edge after the inputs that cause it: one register stands between the inputs and `q`, and no other stage does. The driver changes the inputs at a falling edge. Just after that it checks that `q` still shows the previous expected state, and then it queues the state the reference model predicts for the next rising edge. The monitor takes one item off the queue per rising edge and compares it with `q` a moment after that edge. Each comparison therefore lines up with the edge that produced the result, including on cycles where the mode changes, for example demux straight into hold.

// File: rtl/sel_latch_pkg.sv
package sel_latch_pkg;

    // Operating modes selected by the two active-low controls.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LATCH = 2'd1,
        MODE_CLEAR = 2'd2,
        MODE_DEMUX = 2'd3
    } mode_e;

    // Per-bit control shared by every storage cell.
    typedef struct packed {
        logic load_sel;    // selected bit takes data
        logic zero_unsel;  // unselected bits go to zero
        logic zero_all;    // selected bit also zeroed (when not loading)
    } cell_ctrl_t;

    function automatic mode_e mode_of(input logic zap_n, input logic wr_n);
        mode_e m;
        case ({zap_n, wr_n})
            2'b11:   m = MODE_HOLD;
            2'b10:   m = MODE_LATCH;
            2'b01:   m = MODE_CLEAR;
            default: m = MODE_DEMUX;
        endcase
        return m;
    endfunction

    function automatic cell_ctrl_t ctrl_of(input mode_e m);
        cell_ctrl_t c;
        case (m)
            MODE_LATCH: c = '{load_sel: 1'b1, zero_unsel: 1'b0, zero_all: 1'b0};
            MODE_DEMUX: c = '{load_sel: 1'b1, zero_unsel: 1'b1, zero_all: 1'b0};
            MODE_CLEAR: c = '{load_sel: 1'b0, zero_unsel: 1'b1, zero_all: 1'b1};
            default:    c = '{load_sel: 1'b0, zero_unsel: 1'b0, zero_all: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sel_latch_mode.sv
module sel_latch_mode
    import sel_latch_pkg::*;
(
    input  logic       zap_n,
    input  logic       wr_n,
    output mode_e      mode,
    output cell_ctrl_t ctrl
);
    always_comb begin
        mode = mode_of(zap_n, wr_n);
        ctrl = ctrl_of(mode);
    end
endmodule

// File: rtl/sel_latch_dec.sv
module sel_latch_dec #(
    parameter int IDX_W = 3,
    localparam int NB   = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] idx,
    output logic [NB-1:0]    sel
);
    for (genvar k = 0; k < NB; k++) begin : g_dec
        assign sel[k] = (idx == IDX_W'(k));
    end
endmodule

// File: rtl/sel_latch_cell.sv
module sel_latch_cell
    import sel_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       din,
    input  cell_ctrl_t ctrl,
    output logic       q
);
    logic q_nx;

    always_comb begin
        q_nx = q;
        if (sel) begin
            if (ctrl.load_sel)      q_nx = din;
            else if (ctrl.zero_all) q_nx = 1'b0;
        end else if (ctrl.zero_unsel) begin
            q_nx = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q_nx;
    end
endmodule

// File: rtl/sel_latch_bank.sv
module sel_latch_bank
    import sel_latch_pkg::*;
#(
    parameter int IDX_W = 3,
    localparam int NB   = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             din,
    input  logic             wr_n,
    input  logic             zap_n,
    output logic [NB-1:0]    q
);
    mode_e      mode;
    cell_ctrl_t ctrl;
    logic [NB-1:0] sel;

    sel_latch_mode u_mode (.zap_n(zap_n), .wr_n(wr_n), .mode(mode), .ctrl(ctrl));

    sel_latch_dec #(.IDX_W(IDX_W)) u_dec (.idx(idx), .sel(sel));

    for (genvar k = 0; k < NB; k++) begin : g_cell
        sel_latch_cell u_cell (
            .clk (clk),
            .rst (rst),
            .sel (sel[k]),
            .din (din),
            .ctrl(ctrl),
            .q   (q[k])
        );
    end

    // ---------------- assertions ----------------
    localparam logic [NB-1:0] ONE = NB'(1);

    p_reset_zero_r1: assert property (@(posedge clk) rst |=> (q == '0));

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        (sel == (ONE << idx)));

    p_latch_write_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_LATCH) |=>
        ((q & ~(ONE << $past(idx))) == ($past(q) & ~(ONE << $past(idx)))) &&
        (q[$past(idx)] == $past(din)));

    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (zap_n && wr_n) |=> $stable(q));

    p_demux_r6: assert property (@(posedge clk) disable iff (rst)
        (!zap_n && !wr_n) |=> (q == (NB'($past(din)) << $past(idx))));

    p_clear_all_r7: assert property (@(posedge clk) disable iff (rst)
        (!zap_n && wr_n) |=> (q == '0));
endmodule

// File: tb/sim_sel_latch_bank.sv
module sim_sel_latch_bank;
    localparam int IDX_W = 3;
    localparam int NB = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [IDX_W-1:0] idx = '0;
    logic din = 1'b0;
    logic wr_n = 1'b1;
    logic zap_n = 1'b1;
    logic [NB-1:0] q;

    sel_latch_bank #(.IDX_W(IDX_W)) u0 (
        .clk(clk), .rst(rst), .idx(idx), .din(din),
        .wr_n(wr_n), .zap_n(zap_n), .q(q)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        logic [NB-1:0] exp;
        string         tag;
    } item_t;

    item_t         sb[$];
    logic [NB-1:0] model = '0;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done  = 1'b0;

    function automatic void check(string tag, logic [NB-1:0] act, logic [NB-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: q=%b expected %b at %0t", tag, act, exp, $time);
        end
    endfunction

    // Driver: change inputs at a falling edge, queue the expected next state.
    task automatic drive(input logic r, input logic [IDX_W-1:0] a, input logic d,
                         input logic w, input logic z, input string tag);
        logic [NB-1:0] nx;
        @(negedge clk);
        rst = r; idx = a; din = d; wr_n = w; zap_n = z;
        #1;
        check("R8", q, model);            // nothing moves before the edge
        nx = model;
        if (r) nx = '0;
        else begin
            for (int k = 0; k < NB; k++) begin
                if (k == int'(a)) begin
                    if (!w) nx[k] = d;
                    else if (!z) nx[k] = 1'b0;
                end else if (!z) nx[k] = 1'b0;
            end
        end
        model = nx;
        sb.push_back('{exp: nx, tag: tag});
    endtask

    // Monitor: one result per rising edge, sampled just after it.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, q, it.exp);
        end
    end

    function automatic string tag_of(logic w, logic z);
        if (z && !w) return "R3";
        if (z && w)  return "R4";
        if (!z && !w) return "R6";
        return "R7";
    endfunction

    initial begin
        // R1: reset, including with demux inputs active
        drive(1, 3'd5, 1, 0, 0, "R1");
        drive(1, 3'd0, 0, 1, 1, "R1");
        // R2 / R3: write each index in turn, ones then zeros
        for (int k = 0; k < NB; k++) drive(0, IDX_W'(k), 1, 0, 1, "R2");
        for (int k = NB - 1; k >= 0; k--) drive(0, IDX_W'(k), k[0], 0, 1, "R3");
        // R5: strobe returns high, last written value kept
        drive(0, 3'd6, 1, 0, 1, "R3");
        drive(0, 3'd6, 0, 1, 1, "R5");
        drive(0, 3'd6, 0, 1, 1, "R5");
        // R4: hold while data and index wander
        for (int k = 0; k < 6; k++) drive(0, IDX_W'(k * 3), k[1], 1, 1, "R4");
        // R6: demux on several indices, then demux into hold
        drive(0, 3'd0, 1, 0, 0, "R6");
        drive(0, 3'd7, 1, 0, 0, "R6");
        drive(0, 3'd3, 0, 0, 0, "R6");
        drive(0, 3'd4, 1, 0, 0, "R6");
        drive(0, 3'd1, 0, 1, 1, "R4");
        drive(0, 3'd2, 1, 0, 1, "R3");
        // R7: clear all from a populated bank
        drive(0, 3'd2, 1, 1, 0, "R7");
        drive(0, 3'd5, 1, 0, 1, "R3");
        drive(0, 3'd5, 1, 1, 0, "R7");
        // Random mix of all modes, with an occasional reset
        for (int n = 0; n < 600; n++) begin
            logic w, z, r;
            w = 1'($urandom);
            z = ($urandom % 4) != 0;
            r = ($urandom % 50) == 0;
            drive(r, IDX_W'($urandom), 1'($urandom), w, z, r ? "R1" : tag_of(w, z));
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule